// File: doc/BRIEF.md
# Comma Detecting Character Framer

This block cuts a recovered serial bit stream, arriving one bit per clock, into 10-bit characters. It keeps the latest ten received bits and compares them against a selected framing character at every bit position. When the character turns up off the current boundary, the block restarts its divide-by-ten bit counter at once. The matching ten bits come out as a complete character, and every later character is cut on the new boundary. No confirmation over several characters is required: the first detection is enough.

Two framing characters can be selected. The first is an extended comma, eight significant bits followed by two ignored bits, in either polarity. The second is the full 10-bit K28.5 in either running disparity. The other two select codes are reserved for test and never move the boundary. A global enable input freezes the boundary when it is low. This fast mode should be kept disabled while a built-in self-test stream is received, because that stream carries an aliased K28.5.

Top module: `comma_framer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `char_stb_o` and `realign_o` go low and `char_o` goes to zero. The bit counter restarts, so the first strobe follows the tenth bit clocked after reset is released.
- R2: With no realignment, `char_stb_o` pulses for one cycle after every tenth bit. `char_o` then holds the latest ten bits, with the earliest-received bit in bit 9 and the newest bit in bit 0.
- R3: With `char_sel_i` = 2'b01 (comma), a window whose earliest eight bits are 00111110 or 11000001 is a match. The last two bits are ignored.
- R4: With `char_sel_i` = 2'b10 (K28.5), only the exact windows 0011111010 and 1100000101 match. A comma that is not a K28.5 does not realign.
- R5: With `char_sel_i` = 2'b00 or 2'b11 (reserved for test), no bit pattern changes the boundary and `realign_o` stays low.
- R6: With `frame_en_i` low, no bit pattern changes the boundary and `realign_o` stays low.
- R7: On an enabled match off the current boundary, `char_stb_o` and `realign_o` pulse together in the cycle after the last matching bit is clocked in, and `char_o` holds the matching ten bits. The next strobe follows ten bits later.
- R8: A match that lands exactly on the current boundary gives the normal strobe, with `char_o` equal to the match, and does not pulse `realign_o`.
- R9: Every detection realigns at once, including one that comes only a few bits after a previous realignment.
- R10: `realign_o` is only ever high in a cycle where `char_stb_o` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_i | input | 1 | Serial data, one bit per clock |
| frame_en_i | input | 1 | High lets matches move the character boundary |
| char_sel_i | input | 2 | Framing character: 01 comma, 10 K28.5, 00/11 reserved |
| char_o | output | 10 | Aligned character, earliest bit in bit 9 |
| char_stb_o | output | 1 | One-cycle pulse when `char_o` holds a new character |
| realign_o | output | 1 | One-cycle pulse when the boundary moved |

## Verification
The hardest case to reach from the ports is a match that completes a known number of bits away from the current boundary, with no accidental match in any overlapping window. Every directed scenario therefore starts from a reset, so the boundary phase is known. Zero padding places the pattern at a chosen phase, and the patterns and paddings are picked so that no intermediate window matches. The bench checks the strobe and realignment outputs on every single bit. This covers the grid strobe that falls inside the pattern, the aligned-match case, and a second realignment only a few bits after the first.

// File: rtl/frm_pkg.sv
// Package: shared constants and types for the comma detecting framer.
// Assumes a 10-bit character; patterns are written earliest bit leftmost.
package frm_pkg;

    localparam int CHAR_W = 10;
    localparam int SIG_W  = 8;   // significant bits of the extended comma

    typedef enum logic [1:0] {
        SEL_TEST_LO = 2'b00,
        SEL_COMMA   = 2'b01,
        SEL_K285    = 2'b10,
        SEL_TEST_HI = 2'b11
    } char_sel_t;

    // Positive-polarity patterns; the other polarity is the bitwise inverse.
    localparam logic [CHAR_W-1:0] COMMA_PAT = 10'b0011111000;
    localparam logic [CHAR_W-1:0] K285_PAT  = 10'b0011111010;

    // Mask of compared bits: full width, or the leading SIG_W bits only.
    function automatic logic [CHAR_W-1:0] lead_mask(input int nbits);
        logic [CHAR_W-1:0] m;
        for (int i = 0; i < CHAR_W; i++) begin
            m[CHAR_W-1-i] = (i < nbits);
        end
        return m;
    endfunction

endpackage

// File: rtl/frm_shift.sv
// Module: frm_shift
// Keeps the latest W received bits, earliest bit in the MSB. Also presents
// the window as it will be after the current bit, so a match can be acted
// on in the same edge that clocks the bit in.
// Assumes one valid bit on every clock.
module frm_shift #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_i,
    output logic [W-1:0] win_nx_o
);

    logic [W-1:0] win_q;

    // Window including the bit present at the input now.
    always_comb begin
        win_nx_o = {win_q[W-2:0], bit_i};
    end

    // Shift the new bit in at the LSB end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_nx_o;
        end
    end

endmodule

// File: rtl/frm_match.sv
// Module: frm_match
// Compares a window against the selected framing character in both
// polarities. Comma mode compares the leading SIG_W bits only; K28.5 mode
// compares all bits. Reserved selects and a low enable never report a hit.
// Assumes W equals the package character width.
module frm_match
    import frm_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic [W-1:0] win_i,
    input  logic         en_i,
    input  logic [1:0]   sel_i,
    output logic         hit_o
);

    localparam int NPOL = 2;

    logic [NPOL-1:0] comma_hit;
    logic [NPOL-1:0] k285_hit;

    // One comparator pair per polarity.
    for (genvar p = 0; p < NPOL; p++) begin : g_pol
        localparam logic [W-1:0] CPAT  = (p == 0) ? COMMA_PAT : ~COMMA_PAT;
        localparam logic [W-1:0] KPAT  = (p == 0) ? K285_PAT  : ~K285_PAT;
        localparam logic [W-1:0] CMASK = lead_mask(SIG_W);

        // Masked compare for the comma, exact compare for K28.5.
        always_comb begin
            comma_hit[p] = (((win_i ^ CPAT) & CMASK) == '0);
            k285_hit[p]  = (win_i == KPAT);
        end
    end

    // Pick the comparator set by the select; reserved codes never hit.
    always_comb begin
        unique case (char_sel_t'(sel_i))
            SEL_COMMA: hit_o = en_i && (|comma_hit);
            SEL_K285:  hit_o = en_i && (|k285_hit);
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/frm_bitcnt.sv
// Module: frm_bitcnt
// Divide-by-N bit counter marking the last bit of each character. A restart
// request makes the current bit the last one of a character, so the next
// boundary falls N bits later.
// Assumes N >= 2.
module frm_bitcnt #(
    parameter int N = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic last_o
);

    localparam int CNT_W = $clog2(N);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

    logic [CNT_W-1:0] cnt_q;

    // High while the bit at the input completes a character on the grid.
    always_comb begin
        last_o = (cnt_q == LAST);
    end

    // Count bits; wrap at the boundary or restart on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i || last_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/comma_framer.sv
// Module: comma_framer
// Low-latency character framer. Shifts in one bit per clock, looks for the
// selected framing character at every bit position and, on the first
// detection, restarts the character boundary on it. Outputs are registered.
// Assumes a continuous bit stream with one bit per clock.
module comma_framer
    import frm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_i,
    input  logic              frame_en_i,
    input  logic [1:0]        char_sel_i,
    output logic [CHAR_W-1:0] char_o,
    output logic              char_stb_o,
    output logic              realign_o
);

    logic [CHAR_W-1:0] win_nx;
    logic              hit;
    logic              on_grid;

    frm_shift #(.W(CHAR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_i    (ser_i),
        .win_nx_o (win_nx)
    );

    frm_match #(.W(CHAR_W)) u_match (
        .win_i (win_nx),
        .en_i  (frame_en_i),
        .sel_i (char_sel_i),
        .hit_o (hit)
    );

    frm_bitcnt #(.N(CHAR_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (hit),
        .last_o    (on_grid)
    );

    // Register the character, its strobe and the realignment flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_o     <= '0;
            char_stb_o <= 1'b0;
            realign_o  <= 1'b0;
        end else begin
            char_stb_o <= hit || on_grid;
            realign_o  <= hit && !on_grid;
            if (hit || on_grid) begin
                char_o <= win_nx;
            end
        end
    end

endmodule

// File: rtl/comma_framer_chk.sv
// Module: comma_framer_chk
// Property checker for comma_framer, attached by bind. Tracks the distance
// between strobes with its own counter.
module comma_framer_chk
    import frm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_en_i,
    input logic [1:0]        char_sel_i,
    input logic [CHAR_W-1:0] char_o,
    input logic              char_stb_o,
    input logic              realign_o
);

    localparam int GAP_W = $clog2(CHAR_W + 1) + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic [GAP_W-1:0] gap_q;

    // Clocks since the previous strobe (or since reset), saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (char_stb_o) begin
            gap_q <= GAP_W'(1);
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R10: realignment is reported only together with a character strobe.
    assert_realign_has_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        realign_o |-> char_stb_o);

    // R2 and R8: a strobe that is not a realignment keeps the ten-bit spacing.
    assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb_o && !realign_o) |-> (gap_q == GAP_W'(CHAR_W)));

    // R6: with the enable low, the boundary never moves.
    assert_disabled_no_realign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_en_i) |-> !realign_o);

    // R5: reserved select codes never realign.
    assert_reserved_no_realign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(char_sel_i) == 2'b00 || $past(char_sel_i) == 2'b11) |-> !realign_o);

    // R4: in K28.5 mode a realignment carries an exact K28.5.
    assert_k285_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (realign_o && $past(char_sel_i) == 2'b10) |->
        (char_o == 10'b0011111010 || char_o == 10'b1100000101));

    // R3: in comma mode a realignment carries a comma in its leading bits.
    assert_comma_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (realign_o && $past(char_sel_i) == 2'b01) |->
        (char_o[9:2] == 8'b00111110 || char_o[9:2] == 8'b11000001));

endmodule

bind comma_framer comma_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_en_i (frame_en_i),
    .char_sel_i (char_sel_i),
    .char_o     (char_o),
    .char_stb_o (char_stb_o),
    .realign_o  (realign_o)
);

// File: tb/comma_framer_test.sv
// Directed bench for comma_framer: one task per scenario, each scenario
// starts from reset so the boundary phase is known.
module comma_framer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_i = 1'b0;
    logic       frame_en_i = 1'b0;
    logic [1:0] char_sel_i = 2'b00;
    logic [9:0] char_o;
    logic       char_stb_o;
    logic       realign_o;

    int         n_tests = 0;
    int         n_fail = 0;
    logic [9:0] last_chr = '0;
    bit         done = 1'b0;

    comma_framer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_i      (ser_i),
        .frame_en_i (frame_en_i),
        .char_sel_i (char_sel_i),
        .char_o     (char_o),
        .char_stb_o (char_stb_o),
        .realign_o  (realign_o)
    );

    always #10 clk = ~clk;  // 50 MHz

    task automatic chk_bit(input string tag, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic chk_vec(input string tag, input logic [9:0] got, input logic [9:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Enters at a negedge, leaves at a negedge with reset released.
    task automatic do_reset();
        rst_n = 1'b0;
        ser_i = 1'b0;
        repeat (3) @(negedge clk);
        chk_bit("R1 strobe low in reset", char_stb_o, 1'b0);
        chk_bit("R1 realign low in reset", realign_o, 1'b0);
        chk_vec("R1 char zero in reset", char_o, 10'd0);
        rst_n = 1'b1;
    endtask

    // Sends n bits, v[n-1] first; checks strobe and realign after each bit.
    task automatic send_bits(input logic [31:0] v, input int n,
                             input logic [31:0] stb_mask, input logic [31:0] rea_mask,
                             input string tag);
        for (int i = 0; i < n; i++) begin
            ser_i = v[n-1-i];
            @(posedge clk);
            #5;
            chk_bit({tag, " strobe"}, char_stb_o, stb_mask[i]);
            chk_bit({tag, " realign"}, realign_o, rea_mask[i]);
            if (char_stb_o) last_chr = char_o;
            @(negedge clk);
        end
    endtask

    localparam logic [31:0] P10 = 32'd1 << 9;

    task automatic t_free_run();
        frame_en_i = 1'b0; char_sel_i = 2'b01;
        do_reset();
        send_bits(32'b1010011010, 10, P10, 0, "R1 R2 first char");
        chk_vec("R2 first char", last_chr, 10'b1010011010);
        send_bits(32'b0110101100, 10, P10, 0, "R2 second char");
        chk_vec("R2 second char", last_chr, 10'b0110101100);
    endtask

    task automatic t_comma();
        frame_en_i = 1'b1; char_sel_i = 2'b01;
        do_reset();
        send_bits(0, 10, P10, 0, "R3 pad");
        send_bits(0, 2, 0, 0, "R3 pad");
        send_bits(32'b0011111001, 10, (32'd1 << 7) | P10, P10, "R3 R7 comma+");
        chk_vec("R3 R7 comma+ char", last_chr, 10'b0011111001);
        send_bits(0, 10, P10, 0, "R7 ten bits later");
        chk_vec("R7 char after realign", last_chr, 10'd0);
        send_bits(0, 4, 0, 0, "R3 pad");
        send_bits(32'b1100000110, 10, (32'd1 << 5) | P10, P10, "R3 comma-");
        chk_vec("R3 comma- char", last_chr, 10'b1100000110);
    endtask

    task automatic t_k285();
        frame_en_i = 1'b1; char_sel_i = 2'b10;
        do_reset();
        send_bits(0, 3, 0, 0, "R4 pad");
        send_bits(32'b0011111001, 10, 32'd1 << 6, 0, "R4 comma only");
        send_bits(0, 7, 32'd1 << 6, 0, "R4 grid kept");
        send_bits(0, 2, 0, 0, "R4 pad");
        send_bits(32'b1100000101, 10, (32'd1 << 7) | P10, P10, "R4 K28.5 neg");
        chk_vec("R4 K28.5 neg char", last_chr, 10'b1100000101);
        send_bits(0, 5, 0, 0, "R4 pad");
        send_bits(32'b0011111010, 10, (32'd1 << 4) | P10, P10, "R4 K28.5 pos");
        chk_vec("R4 K28.5 pos char", last_chr, 10'b0011111010);
    endtask

    // Shared body for stimuli that must never move the boundary.
    task automatic frozen_body(input string tag);
        send_bits(0, 4, 0, 0, tag);
        send_bits(32'b0011111010, 10, 32'd1 << 5, 0, tag);
        send_bits(0, 6, 32'd1 << 5, 0, tag);
        send_bits(0, 3, 0, 0, tag);
        send_bits(32'b1100000101, 10, 32'd1 << 6, 0, tag);
        send_bits(0, 7, 32'd1 << 6, 0, tag);
    endtask

    task automatic t_reserved();
        frame_en_i = 1'b1; char_sel_i = 2'b00;
        do_reset();
        frozen_body("R5 select 00");
        char_sel_i = 2'b11;
        do_reset();
        frozen_body("R5 select 11");
    endtask

    task automatic t_disabled();
        frame_en_i = 1'b0; char_sel_i = 2'b01;
        do_reset();
        frozen_body("R6 enable low comma");
        char_sel_i = 2'b10;
        do_reset();
        frozen_body("R6 enable low K28.5");
    endtask

    task automatic t_aligned();
        frame_en_i = 1'b1; char_sel_i = 2'b01;
        do_reset();
        send_bits(32'b0011111011, 10, P10, 0, "R8 aligned match");
        chk_vec("R8 aligned char", last_chr, 10'b0011111011);
        send_bits(0, 10, P10, 0, "R8 grid unchanged");
    endtask

    task automatic t_back_to_back();
        frame_en_i = 1'b1; char_sel_i = 2'b01;
        do_reset();
        send_bits(0, 2, 0, 0, "R9 pad");
        send_bits(32'b0011111001, 10, (32'd1 << 7) | P10, P10, "R9 first");
        send_bits(0, 3, 0, 0, "R9 gap");
        send_bits(32'b1100000110, 10, (32'd1 << 6) | P10, P10, "R9 second");
        chk_vec("R9 second char", last_chr, 10'b1100000110);
        send_bits(0, 10, P10, 0, "R9 new grid");
    endtask

    initial begin
        @(negedge clk);
        t_free_run();
        t_comma();
        t_k285();
        t_reserved();
        t_disabled();
        t_aligned();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule